// File: doc/BRIEF.md
# Single-Clock Receive Elasticity Buffer

This block carries receive nibbles from the recovered receive clock into the local reference clock. The MAC then sees receive data, a valid flag and an error flag that all come from flops on the reference clock, and it never needs the recovered clock. A small circular store sits between the two clocks. Its pointers cross in Gray code through two-flop synchronizers. The store absorbs the slow drift between clocks that differ by up to ±50 ppm, so frames of many kilobytes still come out intact.

The read side holds back each frame until a start level is buffered. A 2-bit code and the speed select pick that level. At 100 Mb/s one nibble leaves per reference clock. At 10 Mb/s the read side moves only on a divide-by-ten strobe, so each nibble is held for ten reference clocks. When the writer's valid falls, an end marker goes into the store. The read side drains the frame, drops valid when it meets the marker, and waits for the start level again before the next frame. Running empty in mid-frame raises an error. So does a nibble dropped because the store was full. The error stays up until the frame ends. With the enable low, the write inputs go straight to the outputs and nothing is buffered.

Top module: `scmii_rx_ebuf`

## Requirements
- R1: At 100 Mb/s with start code 01, a 19,200-nibble frame written with a clock 50 ppm faster or 50 ppm slower than the read clock comes out complete, in the order written, with rd_err low throughout. Shorter frames at any start code do the same.
- R2: The start level counts stored entries. At 100 Mb/s it is 3 entries for codes 01 and 10 and 1 entry for codes 00 and 11. At 10 Mb/s it is 2 entries for every code. rd_valid rises only after the read side sees at least that many entries. So at 100 Mb/s a frame starts about two write clocks later with code 01 than with code 00.
- R3: With spd_100 low, rd_data moves to a new nibble only once every 10 rd_clk cycles. Each nibble is held for exactly 10 cycles.
- R4: After the last nibble of a frame, rd_valid falls and rd_err is low. The number of nibbles delivered equals the number written. The next frame waits for the start level again.
- R5: If the store runs empty in mid-frame, rd_err rises. It stays high while rd_valid stays high.
- R6: A nibble that arrives while the store is full is dropped, and the frame is flagged with rd_err. A later frame at matched clocks is delivered clean.
- R7: With rx_sc_en low, rd_valid equals wr_valid, rd_data equals wr_data, and rd_err is 0, all without a clock.
- R8: rd_err is never high while rd_valid is low.
- R9: During reset, rd_valid, rd_err and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| rd_clk | input | 1 | Reference clock, MAC side |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| rx_sc_en | input | 1 | 1: buffered single-clock receive; 0: pass-through |
| spd_100 | input | 1 | 1: 100 Mb/s, 0: 10 Mb/s |
| start_code | input | 2 | Start level select (default setting 01) |
| wr_valid | input | 1 | Write-side nibble valid, high for the whole frame |
| wr_data | input | DW | Write-side nibble |
| rd_valid | output | 1 | Read-side frame valid |
| rd_data | output | DW | Read-side nibble |
| rd_err | output | 1 | Receive error for the rest of the current frame |

## Verification
The two functions that can land on the same strobe are underflow detection and the end of frame. When the writer is slow, the store empties right at the tail, and on a given strobe the read side must tell "no entry yet" (error) from "end marker present" (close the frame). This is provoked by a frame written with a 30 ns clock against the 20 ns read clock, so the reader keeps catching up until the marker arrives. It is judged by requiring that rd_err rises, never falls while rd_valid is high, and clears together with rd_valid. A following clean frame must then deliver every nibble in order.

// File: rtl/scmii_pkg.sv
package scmii_pkg;

    // start levels in stored entries (nibbles)
    localparam int LVL_FAST_LONG  = 3;
    localparam int LVL_FAST_SHORT = 1;
    localparam int LVL_SLOW       = 2;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } rd_st_e;

    function automatic int start_level(input logic fast, input logic [1:0] code);
        if (!fast) return LVL_SLOW;
        if (code == 2'b01 || code == 2'b10) return LVL_FAST_LONG;
        return LVL_FAST_SHORT;
    endfunction

endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/ebuf_wr.sv
module ebuf_wr #(
    parameter int DW = 4,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   rptr_g_sync,
    output logic [AW:0]   wptr_g,
    input  logic [AW-1:0] rd_addr,
    output logic [DW+1:0] rd_ent
);
    localparam int PW    = AW + 1;
    localparam int EW    = DW + 2;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_W = PW'(DEPTH);

    typedef struct packed {
        logic [AW:0] wbin;
        logic [AW:0] wgray;
        logic        prev_v;
        logic        ovf;
        logic        eofp;
    } wr_s;

    wr_s q, d;
    logic [EW-1:0] mem [DEPTH];
    logic [AW:0]   rbin, wfill;
    logic          full, go_eof, go_dat, we;
    logic [EW-1:0] wdat;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        d      = q;
        rbin   = g2b(rptr_g_sync);
        wfill  = q.wbin - rbin;
        full   = (wfill >= DEPTH_W);
        go_eof = en && (q.eofp || (q.prev_v && !wr_valid));
        go_dat = en && wr_valid && !go_eof;
        we     = (go_eof || go_dat) && !full;
        wdat   = {q.ovf, go_eof, (go_eof ? {DW{1'b0}} : wr_data)};
        d.prev_v = en && wr_valid;
        if (go_eof) d.eofp = full;
        if (we) begin
            d.wbin = q.wbin + 1'b1;
            d.ovf  = 1'b0;
        end else if (go_dat) begin
            d.ovf = 1'b1;                  // nibble dropped: flag the frame
        end
        d.wgray = d.wbin ^ (d.wbin >> 1);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge wr_clk) begin
        if (we) mem[q.wbin[AW-1:0]] <= wdat;
    end

    assign wptr_g = q.wgray;
    assign rd_ent = mem[rd_addr];

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wfill <= DEPTH_W);                                                    // R6
endmodule

// File: rtl/ebuf_rd.sv
module ebuf_rd
    import scmii_pkg::*;
#(
    parameter int DW  = 4,
    parameter int AW  = 4,
    parameter int DIV = 10
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fast,
    input  logic [1:0]    code,
    input  logic [AW:0]   wptr_g_sync,
    output logic [AW:0]   rptr_g,
    output logic [AW-1:0] rd_addr,
    input  logic [DW+1:0] rd_ent,
    output logic [DW-1:0] o_data,
    output logic          o_valid,
    output logic          o_err
);
    localparam int PW = AW + 1;
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

    typedef struct packed {
        logic [AW:0]   rbin;
        logic [AW:0]   rgray;
        rd_st_e        st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dat;
        logic          vld;
        logic          err;
    } rd_s;

    rd_s q, d;
    logic [AW:0] wbin, fill, lvl;
    logic        strb;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        d     = q;
        wbin  = g2b(wptr_g_sync);
        fill  = wbin - q.rbin;
        lvl   = PW'(start_level(fast, code));
        strb  = fast || (q.cnt == '0);
        d.cnt = (q.cnt == CNT_TOP) ? '0 : q.cnt + 1'b1;
        if (!en) begin
            d.st  = ST_WAIT;
            d.vld = 1'b0;
            d.err = 1'b0;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    d.vld = 1'b0;
                    d.err = 1'b0;
                    if (fill >= lvl) begin
                        d.st  = ST_RUN;
                        d.cnt = '0;
                    end
                end
                default: begin
                    if (strb) begin
                        if (fill == '0) begin
                            d.err = 1'b1;          // ran empty in mid-frame
                        end else begin
                            d.rbin = q.rbin + 1'b1;
                            if (rd_ent[DW]) begin  // end marker
                                d.vld = 1'b0;
                                d.err = 1'b0;
                                d.st  = ST_WAIT;
                            end else begin
                                d.dat = rd_ent[DW-1:0];
                                d.vld = 1'b1;
                                d.err = q.err | rd_ent[DW+1];
                            end
                        end
                    end
                end
            endcase
        end
        d.rgray = d.rbin ^ (d.rbin >> 1);
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rptr_g  = q.rgray;
    assign rd_addr = q.rbin[AW-1:0];
    assign o_data  = q.dat;
    assign o_valid = q.vld;
    assign o_err   = q.err;

    AST_START_LEVEL: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(q.st == ST_RUN) |-> $past(fill) >= $past(lvl));                 // R2
    AST_SLOW_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fast && q.st == ST_RUN && q.cnt != '0) |=> $stable(q.dat));          // R3
    AST_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (q.err && q.vld && en) |=> (q.err || !q.vld));                         // R5
    AST_ERR_IN_FRAME: assert property (@(posedge rd_clk) disable iff (!rst_n)
        q.err |-> q.vld);                                                      // R8
endmodule

// File: rtl/scmii_rx_ebuf.sv
module scmii_rx_ebuf #(
    parameter int DW  = 4,
    parameter int AW  = 4,
    parameter int DIV = 10
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rx_sc_en,
    input  logic          spd_100,
    input  logic [1:0]    start_code,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_err
);
    localparam int PW = AW + 1;
    localparam int EW = DW + 2;

    logic [PW-1:0] wptr_g, wptr_g_rs, rptr_g, rptr_g_ws;
    logic [AW-1:0] rd_addr;
    logic [EW-1:0] rd_ent;
    logic [DW-1:0] b_data;
    logic          b_valid, b_err;

    ebuf_wr #(.DW(DW), .AW(AW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .en(rx_sc_en),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rptr_g_sync(rptr_g_ws), .wptr_g(wptr_g),
        .rd_addr(rd_addr), .rd_ent(rd_ent)
    );

    ebuf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wptr_g), .q(wptr_g_rs));
    ebuf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rptr_g), .q(rptr_g_ws));

    ebuf_rd #(.DW(DW), .AW(AW), .DIV(DIV)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .en(rx_sc_en),
        .fast(spd_100), .code(start_code),
        .wptr_g_sync(wptr_g_rs), .rptr_g(rptr_g),
        .rd_addr(rd_addr), .rd_ent(rd_ent),
        .o_data(b_data), .o_valid(b_valid), .o_err(b_err)
    );

    // R7: pass-through when single-clock receive is off
    assign rd_valid = rx_sc_en ? b_valid : wr_valid;
    assign rd_data  = rx_sc_en ? b_data  : wr_data;
    assign rd_err   = rx_sc_en ? b_err   : 1'b0;
endmodule

// File: tb/sim_scmii_rx_ebuf.sv
`timescale 1ns/1fs
module sim_scmii_rx_ebuf;
    logic rclk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, spd = 1'b1, wv = 1'b0;
    logic [1:0] code = 2'b01;
    logic [3:0] wd = 4'd0;
    logic rd_valid, rd_err;
    logic [3:0] rd_data;
    real wper = 20.0;

    int total = 0, bad = 0;
    int cyc = 0, start_cyc = 0, rise_cyc = 0;
    int got, dbad, spbad, done = 0, r8_bad = 0, k = 0;
    bit errseen, errdrop, pv = 1'b0, pe = 1'b0;
    logic [3:0] exp_nib = 4'd0, last = 4'd0;

    scmii_rx_ebuf u0 (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .rx_sc_en(en),
        .spd_100(spd), .start_code(code), .wr_valid(wv), .wr_data(wd),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
    );

    always #10 rclk = ~rclk;
    always begin #(wper / 2.0); wclk = ~wclk; end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge rclk) begin
        cyc++;
        if (cyc > 190000) begin
            total++; bad++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    // monitor on the falling edge of the read clock
    always @(negedge rclk) begin
        if (en) begin
            if (rd_err && !rd_valid) r8_bad++;
            if (rd_valid) begin
                if (!pv) begin k = 0; rise_cyc = cyc; end
                if (spd || (k % 10) == 0) begin
                    got++;
                    if (rd_data !== exp_nib) dbad++;
                    exp_nib = exp_nib + 4'd1;
                    last = rd_data;
                end else if (rd_data !== last) spbad++;
                if (rd_err) errseen = 1'b1;
                if (pe && !rd_err) errdrop = 1'b1;
                k++;
            end else if (pv) done++;
        end
        pv = rd_valid && en;
        pe = rd_err && en;
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frame(input int n, input logic [3:0] base);
        int d0;
        got = 0; dbad = 0; spbad = 0; errseen = 1'b0; errdrop = 1'b0;
        exp_nib = base; d0 = done;
        @(negedge wclk);
        start_cyc = cyc;
        for (int i = 0; i < n; i++) begin
            wv = 1'b1;
            wd = base + 4'(i);
            @(negedge wclk);
        end
        wv = 1'b0;
        for (int g = 0; g < 5000 && done == d0; g++) @(negedge rclk);
        repeat (20) @(negedge rclk);
        repeat (3) @(negedge wclk);
    endtask

    task automatic clean(input string tag, input int n);
        chk({tag, " count"}, got == n, got, n);
        chk({tag, " order"}, dbad == 0, dbad, 0);
        chk({tag, " no error"}, !errseen, errseen, 0);
    endtask

    int lat [4];
    int ls0, ls1, n;
    logic [3:0] b;

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge rclk);
        // R9 reset values
        chk("R9 valid in reset", rd_valid == 1'b0, rd_valid, 0);
        chk("R9 err in reset", rd_err == 1'b0, rd_err, 0);
        chk("R9 data in reset", rd_data == 4'd0, rd_data, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge rclk);

        // R7 pass-through
        en = 1'b0; wv = 1'b1; wd = 4'hA; #1;
        chk("R7 bypass data", rd_data == 4'hA, rd_data, 4'hA);
        chk("R7 bypass valid", rd_valid == 1'b1, rd_valid, 1);
        wd = 4'h5; #1;
        chk("R7 bypass data 2", rd_data == 4'h5, rd_data, 4'h5);
        chk("R7 bypass err", rd_err == 1'b0, rd_err, 0);
        wv = 1'b0; #1;
        chk("R7 bypass valid low", rd_valid == 1'b0, rd_valid, 0);
        repeat (3) @(negedge rclk);
        en = 1'b1;
        repeat (5) @(negedge rclk);

        // R2 start levels at 100 Mb/s
        for (int c = 0; c < 4; c++) begin
            code = 2'(c);
            frame(24, 4'(c * 3));
            lat[c] = rise_cyc - start_cyc;
            clean("R4 level frame", 24);
        end
        chk("R2 code01 later than code00", (lat[1] - lat[0]) >= 1 && (lat[1] - lat[0]) <= 3,
            lat[1] - lat[0], 2);
        chk("R2 code10 same as code01", (lat[2] - lat[1]) >= -1 && (lat[2] - lat[1]) <= 1,
            lat[2], lat[1]);
        chk("R2 code11 same as code00", (lat[3] - lat[0]) >= -1 && (lat[3] - lat[0]) <= 1,
            lat[3], lat[0]);

        // R1 constrained random frames
        for (int r = 0; r < 6; r++) begin
            n = 30 + $urandom_range(0, 150);
            b = 4'($urandom_range(0, 15));
            code = 2'($urandom_range(0, 3));
            wper = ($urandom_range(0, 1) == 1) ? 19.999 : 20.001;
            frame(n, b);
            clean("R1 random frame", n);
        end

        // R1 maximum frame at +50 ppm and -50 ppm, start code 01
        code = 2'b01;
        wper = 19.999;
        frame(19200, 4'h3);
        clean("R1 max frame +50ppm", 19200);
        wper = 20.001;
        frame(19200, 4'h9);
        clean("R1 max frame -50ppm", 19200);

        // R3 / R2 at 10 Mb/s
        spd = 1'b0; wper = 200.0;
        code = 2'b00;
        frame(20, 4'h1);
        ls0 = rise_cyc - start_cyc;
        clean("R4 slow frame", 20);
        code = 2'b01;
        frame(20, 4'h7);
        ls1 = rise_cyc - start_cyc;
        chk("R2 slow level code-independent", (ls1 - ls0) >= -1 && (ls1 - ls0) <= 1, ls1, ls0);
        chk("R2 slow level two entries", ls0 >= 14 && ls0 <= 26, ls0, 20);
        wper = 199.99;
        frame(100, 4'h2);
        clean("R3 slow frame fast writer", 100);
        chk("R3 ten-clock hold", spbad == 0, spbad, 0);
        wper = 200.01;
        frame(100, 4'hC);
        clean("R3 slow frame slow writer", 100);
        chk("R3 ten-clock hold 2", spbad == 0, spbad, 0);

        // R5 underflow: writer slower than reader
        spd = 1'b1; code = 2'b00; wper = 30.0;
        frame(60, 4'h0);
        chk("R5 underflow flagged", errseen, errseen, 1);
        chk("R5 error held to frame end", !errdrop, errdrop, 0);
        chk("R4 valid low after frame", rd_valid == 1'b0, rd_valid, 0);
        chk("R4 err low after frame", rd_err == 1'b0, rd_err, 0);

        // R6 overflow: writer twice as fast
        code = 2'b01; wper = 10.0;
        frame(300, 4'h4);
        chk("R6 overflow flagged", errseen, errseen, 1);
        chk("R6 nibbles dropped", got < 300, got, 300);
        chk("R5 overflow error held", !errdrop, errdrop, 0);
        wper = 20.0;
        frame(40, 4'hE);
        clean("R6 recovery frame", 40);

        chk("R8 err only with valid", r8_bad == 0, r8_bad, 0);
        summary();
        $finish;
    end
endmodule